// File: doc/BRIEF.md
# Receiver Power-Mode and Clock-Output Controller

This block turns the operating-mode bits of a zero-IF receiver into the enable lines for its sections: the RF synthesizer, the VCO, the receive path and the system-clock PLL with its output buffer. A chip-enable pin gates every mode. The pin is asynchronous, so the block first resynchronises it to the reference clock and then detects its rising edge.

When the receive path is requested, the block first runs a VCO calibration window. This window is a fixed number of reference cycles, and the receive-path enable stays low until it ends. The clock PLL comes up by itself after power-up once the pin is high. Software can stop it in two ways:
- a soft stop, which the block clears on the next rising edge of the pin;
- a hard stop through a level bit that the pin does not affect.

The block also decodes the divider ratio for the clock output.

Top module: `rxpm_ctrl`

## Requirements
- R1: While the reset input is low, and on the first sampled cycles after it, every output enable is low and clk_div is 0. The soft clock-stop flag powers up cleared.
- R2: chip_en_pin passes through a two-flop synchroniser. A change on the pin reaches the enables after the second rising clock edge and not after the first.
- R3: With the synchronised pin high, the mode bits select the enables as follows. syn_on=0 enables nothing, whatever rx_on is. syn_on=1 with rx_on=0 raises syn_en and vco_en. syn_on=1 with rx_on=1 additionally requests the receive path.
- R4: While the synchronised pin is low, syn_en, vco_en, rx_en, cal_busy, clkpll_en and clkout_en are all low.
- R5: When the receive request (synchronised pin, syn_on and rx_on all high) becomes true, cal_busy is high and rx_en is low for exactly CAL_CYCLES rising edges. After that, cal_busy is low and rx_en is high. The two are never high together.
- R6: If the receive request drops during the window, the window is cancelled. A new request starts a full window again.
- R7: clkpll_en and clkout_en are high when the synchronised pin is high, the soft-stop flag is clear and clk_off is low. With no software action, the clock PLL runs once the pin is high.
- R8: A write (clkon_wr=1) stores clkon_val into the soft-stop flag, and a set flag powers the clock PLL down. The flag clears on the clock edge after a synchronised rising edge of the pin. This clear takes priority over a write on the same edge.
- R9: clk_off=1 holds clkpll_en and clkout_en low, and a rising edge of the pin does not release them.
- R10: While clkout_en is high, clk_div follows cko: 00 gives 4 (the default), 01 gives 2, 10 gives 4 and 11 gives 8. While clkout_en is low, clk_div is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| chip_en_pin | input | 1 | Asynchronous chip-enable pin |
| syn_on | input | 1 | Synthesizer mode bit |
| rx_on | input | 1 | Receive mode bit |
| clkon_wr | input | 1 | Write strobe for the soft clock-stop flag |
| clkon_val | input | 1 | Value written into the soft clock-stop flag |
| clk_off | input | 1 | Hard clock-PLL power-down bit |
| cko | input | 2 | Clock output divider select |
| syn_en | output | 1 | RF synthesizer enable |
| vco_en | output | 1 | VCO and regulator enable |
| rx_en | output | 1 | Receive path enable |
| cal_busy | output | 1 | VCO calibration window active |
| clkpll_en | output | 1 | Clock PLL enable |
| clkout_en | output | 1 | System clock output buffer enable |
| clk_div | output | 4 | Clock output divider ratio (0 when the output is off) |

## Verification
Several relations are checked on every cycle:
- a low synchronised pin keeps every enable low;
- the receive path is never on without the synthesizer and VCO;
- the calibration window and the receive enable never overlap, and every rise of rx_en comes straight after a calibration cycle;
- clk_off blocks the clock;
- the clock is released after a pin rise;
- an enabled output always carries a legal ratio.

Some behaviours can only be shown by the bench's scenarios:
- the exact two-edge synchroniser delay;
- the exact length of the window and its restart after an abort;
- the priority of the edge-clear over a write on the same edge;
- the full ratio mapping.

// File: rtl/rxpm_pkg.sv
package rxpm_pkg;
  localparam int unsigned DIV_W = 4;

  typedef enum logic [1:0] {
    CKO_DEFAULT = 2'b00,
    CKO_DIV2    = 2'b01,
    CKO_DIV4    = 2'b10,
    CKO_DIV8    = 2'b11
  } cko_sel_e;

  localparam logic [DIV_W-1:0] DIV_RATIO_DEFAULT = 4'd4;

  function automatic logic [DIV_W-1:0] div_ratio(input logic [1:0] sel);
    logic [DIV_W-1:0] r;
    unique case (cko_sel_e'(sel))
      CKO_DIV2: r = 4'd2;
      CKO_DIV4: r = 4'd4;
      CKO_DIV8: r = 4'd8;
      default:  r = DIV_RATIO_DEFAULT;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rxpm_sync.sv
module rxpm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rxpm_cal_timer.sv
module rxpm_cal_timer #(
  parameter int unsigned CAL_CYCLES = 910
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CAL_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_end;

  assign at_end = (cnt_q == CNT_END);
  assign cnt_en = ~req_i | ~at_end;

  always_comb begin
    if (!req_i) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = req_i & ~at_end;
  assign done_o = req_i & at_end;
endmodule

// File: rtl/rxpm_clk_ctrl.sv
module rxpm_clk_ctrl
  import rxpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_lvl_i,
  input  logic             chip_rise_i,
  input  logic             stop_wr_i,
  input  logic             stop_val_i,
  input  logic             hard_off_i,
  input  logic [1:0]       sel_i,
  output logic             pll_en_o,
  output logic             out_en_o,
  output logic [DIV_W-1:0] div_o
);
  logic soft_stop_q;
  logic soft_stop_d;
  logic soft_stop_en;

  assign soft_stop_en = chip_rise_i | stop_wr_i;

  always_comb begin
    if (chip_rise_i) soft_stop_d = 1'b0;
    else             soft_stop_d = stop_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            soft_stop_q <= 1'b0;
    else if (soft_stop_en) soft_stop_q <= soft_stop_d;
  end

  assign pll_en_o = chip_lvl_i & ~soft_stop_q & ~hard_off_i;
  assign out_en_o = pll_en_o;
  assign div_o    = out_en_o ? div_ratio(sel_i) : '0;
endmodule

// File: rtl/rxpm_ctrl.sv
module rxpm_ctrl
  import rxpm_pkg::*;
#(
  parameter int unsigned CAL_CYCLES  = 910,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en_pin,
  input  logic             syn_on,
  input  logic             rx_on,
  input  logic             clkon_wr,
  input  logic             clkon_val,
  input  logic             clk_off,
  input  logic [1:0]       cko,
  output logic             syn_en,
  output logic             vco_en,
  output logic             rx_en,
  output logic             cal_busy,
  output logic             clkpll_en,
  output logic             clkout_en,
  output logic [DIV_W-1:0] clk_div
);
  logic rst_meta_q;
  logic rst_sync_q;
  logic chip_s;
  logic chip_rise;
  logic syn_req;
  logic rx_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rxpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (chip_en_pin),
    .level_o (chip_s),
    .rise_o  (chip_rise)
  );

  assign syn_req = chip_s & syn_on;
  assign rx_req  = syn_req & rx_on;

  rxpm_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .req_i  (rx_req),
    .busy_o (cal_busy),
    .done_o (rx_en)
  );

  assign syn_en = syn_req;
  assign vco_en = syn_req;

  rxpm_clk_ctrl u_clk (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .chip_lvl_i  (chip_s),
    .chip_rise_i (chip_rise),
    .stop_wr_i   (clkon_wr),
    .stop_val_i  (clkon_val),
    .hard_off_i  (clk_off),
    .sel_i       (cko),
    .pll_en_o    (clkpll_en),
    .out_en_o    (clkout_en),
    .div_o       (clk_div)
  );
endmodule

module rxpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chip_s,
  input logic       clk_off,
  input logic       syn_en,
  input logic       vco_en,
  input logic       rx_en,
  input logic       cal_busy,
  input logic       clkpll_en,
  input logic       clkout_en,
  input logic [3:0] clk_div
);
  a_r4_pin_low_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_s |-> !(syn_en || vco_en || rx_en || cal_busy || clkpll_en || clkout_en));

  a_r3_rx_needs_syn: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> (syn_en && vco_en));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_busy && rx_en));

  a_r5_cal_before_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !$past(rx_en)) |-> $past(cal_busy));

  a_r9_hard_off: assert property (@(posedge clk) disable iff (!rst_n)
    clk_off |-> (!clkpll_en && !clkout_en));

  a_r8_rise_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_s) ##1 chip_s |-> (clkpll_en == !clk_off));

  a_r10_legal_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> (clk_div == 4'd2 || clk_div == 4'd4 || clk_div == 4'd8));
endmodule

bind rxpm_ctrl rxpm_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chip_s    (chip_s),
  .clk_off   (clk_off),
  .syn_en    (syn_en),
  .vco_en    (vco_en),
  .rx_en     (rx_en),
  .cal_busy  (cal_busy),
  .clkpll_en (clkpll_en),
  .clkout_en (clkout_en),
  .clk_div   (clk_div)
);

// File: tb/rxpm_ctrl_tb.sv
`timescale 1ns/1ps
module rxpm_ctrl_tb;
  localparam int CAL = 910;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       chip_en_pin;
  logic       syn_on, rx_on, clkon_wr, clkon_val, clk_off;
  logic [1:0] cko;
  logic       syn_en, vco_en, rx_en, cal_busy, clkpll_en, clkout_en;
  logic [3:0] clk_div;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxpm_ctrl #(.CAL_CYCLES(CAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en_pin(chip_en_pin),
    .syn_on(syn_on), .rx_on(rx_on), .clkon_wr(clkon_wr), .clkon_val(clkon_val),
    .clk_off(clk_off), .cko(cko),
    .syn_en(syn_en), .vco_en(vco_en), .rx_en(rx_en), .cal_busy(cal_busy),
    .clkpll_en(clkpll_en), .clkout_en(clkout_en), .clk_div(clk_div)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_div(input bit on, input logic [1:0] s);
    if (!on) return 0;
    case (s)
      2'b01: return 2;
      2'b11: return 8;
      default: return 4;
    endcase
  endfunction

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    rst_n = 1'b0; chip_en_pin = 1'b1; syn_on = 1'b1; rx_on = 1'b1;
    clkon_wr = 1'b0; clkon_val = 1'b0; clk_off = 1'b0; cko = 2'b00;
    edges(3);
    // R1: reset holds everything off
    chk("R1 syn_en", syn_en, 0);
    chk("R1 clkpll_en", clkpll_en, 0);
    chk("R1 clk_div", clk_div, 0);
    chip_en_pin = 1'b0; syn_on = 1'b0; rx_on = 1'b0;
    rst_n = 1'b1;
    edges(5);
    chk("R1 after release", clkout_en, 0);

    // R2: two-edge synchroniser; R7: clock PLL auto-on
    chip_en_pin = 1'b1; syn_on = 1'b1;
    edges(1);
    chk("R2 one edge", syn_en, 0);
    edges(1);
    chk("R2 two edges", syn_en, 1);
    chk("R7 auto clock", clkpll_en, 1);
    chk("R10 default div", clk_div, 4);

    // R3: mode decode
    syn_on = 1'b0; rx_on = 1'b1; edges(1);
    chk("R3 idle syn", syn_en, 0);
    chk("R3 idle busy", cal_busy, 0);
    chk("R3 idle rx", rx_en, 0);
    syn_on = 1'b1; rx_on = 1'b0; edges(1);
    chk("R3 syn vco", vco_en, 1);
    chk("R3 syn rx", rx_en, 0);

    // R5: calibration window length
    rx_on = 1'b1;
    #1;
    chk("R5 busy start", cal_busy, 1);
    edges(CAL - 1);
    chk("R5 busy last", cal_busy, 1);
    chk("R5 rx held", rx_en, 0);
    edges(1);
    chk("R5 busy end", cal_busy, 0);
    chk("R5 rx on", rx_en, 1);
    chk("R3 rx mode syn", syn_en, 1);

    // R6: abort and restart
    rx_on = 1'b0; edges(1);
    rx_on = 1'b1; edges(300);
    rx_on = 1'b0; edges(1);
    chk("R6 aborted rx", rx_en, 0);
    rx_on = 1'b1; edges(CAL - 1);
    chk("R6 full window busy", cal_busy, 1);
    chk("R6 full window rx", rx_en, 0);
    edges(1);
    chk("R6 rx after restart", rx_en, 1);

    // R4: pin low kills everything
    chip_en_pin = 1'b0; edges(2);
    chk("R4 rx off", rx_en, 0);
    chk("R4 syn off", syn_en, 0);
    chk("R4 clk off", clkpll_en, 0);
    chk("R4 div", clk_div, 0);

    // R8: soft stop and clear on rising edge
    chip_en_pin = 1'b1; edges(3);
    clkon_wr = 1'b1; clkon_val = 1'b1; edges(1);
    clkon_wr = 1'b0; clkon_val = 1'b0;
    chk("R8 soft stop", clkpll_en, 0);
    chk("R8 soft stop out", clkout_en, 0);
    chip_en_pin = 1'b0; edges(3);
    chip_en_pin = 1'b1; edges(2);
    chk("R8 before clear", clkpll_en, 0);
    edges(1);
    chk("R8 cleared", clkpll_en, 1);
    // R8: rise beats a write on the same edge
    clkon_wr = 1'b1; clkon_val = 1'b1; edges(1);
    clkon_wr = 1'b0; clkon_val = 1'b0;
    chip_en_pin = 1'b0; edges(3);
    chip_en_pin = 1'b1; edges(2);
    clkon_wr = 1'b1; clkon_val = 1'b1; edges(1);
    clkon_wr = 1'b0; clkon_val = 1'b0;
    chk("R8 rise priority", clkpll_en, 1);

    // R9: hard off survives a pin rise
    clk_off = 1'b1; edges(1);
    chk("R9 hard off", clkout_en, 0);
    chip_en_pin = 1'b0; edges(3);
    chip_en_pin = 1'b1; edges(4);
    chk("R9 after rise", clkpll_en, 0);
    clk_off = 1'b0; edges(1);
    chk("R9 released", clkpll_en, 1);

    // R10 directed mapping
    for (int s = 0; s < 4; s++) begin
      cko = s[1:0]; #1;
      chk("R10 mapping", clk_div, exp_div(1'b1, s[1:0]));
    end

    // Random decode with pin high and soft stop clear
    for (int i = 0; i < 60; i++) begin
      logic [4:0] r;
      r = 5'($urandom());
      syn_on = r[0]; rx_on = r[1]; clk_off = r[2]; cko = r[4:3];
      edges(1);
      chk("R3 random syn", syn_en, int'(r[0]));
      chk("R3 random vco", vco_en, int'(r[0]));
      chk("R9 random clk", clkpll_en, int'(!r[2]));
      chk("R10 random div", clk_div, exp_div(!r[2], r[4:3]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule